// File: doc/BRIEF.md
# Masked Associative Search Array

This block is a small content-addressable store of `WORDS` entries, each `WIDTH` bits wide. Every entry is compared against a held search key in the same cycle. A column-enable register picks which bit positions take part in the compare. The outcome is a per-entry match vector. The block keeps two such vectors: the one from the latest search and the one from the search before it. A later search can therefore be narrowed by the result of an earlier one, so a multi-field lookup can be built from several searches in a row.

The block accepts one command per cycle on a small command port. The commands are:
- an addressed store of an entry,
- an addressed read of an entry,
- a load of the search key,
- a load of the column-enable mask,
- a search, either fresh or chained,
- a read of the lowest-numbered matching entry.

A priority picker reports whether any entry matched, and which matching entry has the lowest index.

Top module: `masked_assoc_array`

## Requirements
- R1: An addressed read (op 2) presents `rd_valid` and the stored word of `cmd_addr` on `rd_data` one cycle after the command. An addressed store (op 1) writes `cmd_data` at `cmd_addr` and marks that entry occupied.
- R2: The key (op 3) and the mask (op 4) are each loaded from `cmd_data`. Each keeps its value across any number of searches until it is loaded again. After reset the key is 0 and the mask is all ones.
- R3: A fresh search (op 5 with `cmd_chain`=0) sets `match_vec` bit i to 1 exactly when entry i is occupied and equals the key in every enabled column.
- R4: A mask bit of 0 excludes that column from the compare, and the column counts as equal. With the mask all zero, every occupied entry matches.
- R5: An entry that has never been stored never matches. Reset marks all entries unoccupied and clears `match_vec` and `prev_vec`.
- R6: On every search, `prev_vec` takes the value that `match_vec` held before the search, in the same edge that `match_vec` takes its new value.
- R7: A chained search (op 5 with `cmd_chain`=1) loads `match_vec` with the new match vector ANDed with the previous `match_vec`.
- R8: `hit` is 1 exactly when `match_vec` is nonzero. When `hit` is 1, `hit_idx` is the lowest index whose `match_vec` bit is set.
- R9: A read-first-match (op 6) presents `rd_valid` one cycle later. `rd_data` then holds the entry at the `hit_idx` of the command cycle, or 0 if `hit` was 0.
- R10: `rd_valid` is 1 only in the cycle that follows an op 2 or op 6 command.
- R11: All commands other than a search, and idle cycles with `cmd_valid`=0, leave `match_vec` and `prev_vec` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 0 idle, 1 store, 2 read, 3 key, 4 mask, 5 search, 6 read first match |
| cmd_chain | input | 1 | Search mode: 1 narrows the search with the previous result |
| cmd_addr | input | $clog2(WORDS) | Entry index for store and read |
| cmd_data | input | WIDTH | Data for store, key or mask |
| rd_valid | output | 1 | Read data present |
| rd_data | output | WIDTH | Read data |
| match_vec | output | WORDS | Result of the latest search |
| prev_vec | output | WORDS | Result of the search before the latest one |
| hit | output | 1 | Any entry set in `match_vec` |
| hit_idx | output | $clog2(WORDS) | Lowest set index of `match_vec` |

## Verification
The hardest state to reach is a chained search whose raw match differs from its narrowed result. Reaching it needs occupied entries that agree with one key under one mask and with a second key under another mask, with only part of the two sets overlapping. The stimulus stores entries whose high and low bytes are chosen so that the sets overlap in one entry. It then runs a partial-mask search, reloads the key and mask, and issues a chained search. A read-first-match follows, which shows the narrowed priority pick at the data port.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_STORE    = 3'd1,
        OP_READ     = 3'd2,
        OP_SET_KEY  = 3'd3,
        OP_SET_MASK = 3'd4,
        OP_SEARCH   = 3'd5,
        OP_READ_HIT = 3'd6
    } op_e;
endpackage

// File: rtl/assoc_store.sv
module assoc_store #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_addr,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic [IDX_W-1:0]            rd_addr,
    output logic [WIDTH-1:0]            rd_word,
    output logic [WORDS-1:0][WIDTH-1:0] words,
    output logic [WORDS-1:0]            occupied
);
    typedef struct packed {
        logic [WORDS-1:0][WIDTH-1:0] data;
        logic [WORDS-1:0]            occ;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data[wr_addr] = wr_data;
            st_d.occ[wr_addr]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word  = st_q.data[rd_addr];
    assign words    = st_q.data;
    assign occupied = st_q.occ;
endmodule

// File: rtl/assoc_slice_cmp.sv
module assoc_slice_cmp #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic [WORDS-1:0][WIDTH-1:0] words,
    input  logic [WORDS-1:0]            occupied,
    input  logic [WIDTH-1:0]            key,
    input  logic [WIDTH-1:0]            col_en,
    output logic [WORDS-1:0]            raw_match
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WIDTH-1:0] diff;
        assign diff         = (words[w] ^ key) & col_en;
        assign raw_match[w] = occupied[w] && (diff == '0);
    end
endmodule

// File: rtl/assoc_first_hit.sv
module assoc_first_hit #(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [WORDS-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/masked_assoc_array.sv
module masked_assoc_array
    import assoc_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_chain,
    input  logic [IDX_W-1:0] cmd_addr,
    input  logic [WIDTH-1:0] cmd_data,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic [WORDS-1:0] match_vec,
    output logic [WORDS-1:0] prev_vec,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    typedef struct packed {
        logic [WIDTH-1:0] key;
        logic [WIDTH-1:0] col_en;
        logic [WORDS-1:0] ind;
        logic [WORDS-1:0] tmp;
        logic             rdv;
        logic [WIDTH-1:0] rdd;
    } regs_t;

    localparam regs_t REGS_RST = '{key: '0, col_en: '1, ind: '0, tmp: '0, rdv: 1'b0, rdd: '0};

    regs_t r_d, r_q;
    op_e   op;

    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [WORDS-1:0]            occupied;
    logic [WORDS-1:0]            raw_match;
    logic [WIDTH-1:0]            rd_word;
    logic [IDX_W-1:0]            rd_sel;
    logic                        first_any;
    logic [IDX_W-1:0]            first_idx;
    logic                        do_store;

    assign op       = op_e'(cmd_op);
    assign do_store = cmd_valid && (op == OP_STORE);
    assign rd_sel   = (op == OP_READ_HIT) ? first_idx : cmd_addr;

    assoc_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_store),
        .wr_addr  (cmd_addr),
        .wr_data  (cmd_data),
        .rd_addr  (rd_sel),
        .rd_word  (rd_word),
        .words    (words),
        .occupied (occupied)
    );

    assoc_slice_cmp #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
        .words     (words),
        .occupied  (occupied),
        .key       (r_q.key),
        .col_en    (r_q.col_en),
        .raw_match (raw_match)
    );

    assoc_first_hit #(.WORDS(WORDS)) u_first (
        .vec (r_q.ind),
        .any (first_any),
        .idx (first_idx)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rdv = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_READ: begin
                    r_d.rdv = 1'b1;
                    r_d.rdd = rd_word;
                end
                OP_READ_HIT: begin
                    r_d.rdv = 1'b1;
                    r_d.rdd = first_any ? rd_word : '0;
                end
                OP_SET_KEY:  r_d.key    = cmd_data;
                OP_SET_MASK: r_d.col_en = cmd_data;
                OP_SEARCH: begin
                    r_d.tmp = r_q.ind;
                    r_d.ind = cmd_chain ? (raw_match & r_q.ind) : raw_match;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign rd_valid  = r_q.rdv;
    assign rd_data   = r_q.rdd;
    assign match_vec = r_q.ind;
    assign prev_vec  = r_q.tmp;
    assign hit       = first_any;
    assign hit_idx   = first_idx;
endmodule

// File: rtl/assoc_chk.sv
module assoc_chk #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_chain,
    input logic             rd_valid,
    input logic [WIDTH-1:0] rd_data,
    input logic [WORDS-1:0] match_vec,
    input logic [WORDS-1:0] prev_vec,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx
);
    localparam logic [WORDS-1:0] ONE = WORDS'(1);

    logic is_search, is_rd, is_rd_hit;
    logic [WORDS-1:0] below_idx;
    assign is_search = cmd_valid && (cmd_op == 3'd5);
    assign is_rd_hit = cmd_valid && (cmd_op == 3'd6);
    assign is_rd     = cmd_valid && ((cmd_op == 3'd2) || is_rd_hit);
    assign below_idx = (ONE << hit_idx) - ONE;

    // R6
    prev_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_search |=> prev_vec == $past(match_vec));

    // R7
    chain_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_search && cmd_chain) |=> (match_vec & ~$past(match_vec)) == '0);

    // R11
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_search |=> $stable(match_vec) && $stable(prev_vec));

    // R8
    hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (match_vec != '0));

    // R8
    lowest_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx] && ((match_vec & below_idx) == '0));

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rd_valid);

    // R10
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid);

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd_hit && !hit) |=> rd_data == '0);
endmodule

bind masked_assoc_array assoc_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_chain (cmd_chain),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .match_vec (match_vec),
    .prev_vec  (prev_vec),
    .hit       (hit),
    .hit_idx   (hit_idx)
);

// File: tb/sim_masked_assoc_array.sv
module sim_masked_assoc_array;
    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IDX_W = $clog2(WORDS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic             cmd_chain = 1'b0;
    logic [IDX_W-1:0] cmd_addr = '0;
    logic [WIDTH-1:0] cmd_data = '0;
    logic             rd_valid;
    logic [WIDTH-1:0] rd_data;
    logic [WORDS-1:0] match_vec, prev_vec;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic [WIDTH-1:0] exp_q[$];

    // reference model, built from the requirements
    logic [WIDTH-1:0] m_mem [WORDS];
    logic [WORDS-1:0] m_occ = '0;
    logic [WIDTH-1:0] m_key = '0;
    logic [WIDTH-1:0] m_mask = '1;
    logic [WORDS-1:0] m_ind = '0;
    logic [WORDS-1:0] m_tmp = '0;

    always #10 clk = ~clk;

    masked_assoc_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int first_set(logic [WORDS-1:0] v);
        for (int i = 0; i < WORDS; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check_vectors(string req);
        check({req, " match_vec"}, 32'(match_vec), 32'(m_ind));
        check({req, " prev_vec"}, 32'(prev_vec), 32'(m_tmp));
        check({req, " hit"}, 32'(hit), 32'(m_ind != '0));
        if (m_ind != '0) check({req, " hit_idx"}, 32'(hit_idx), 32'(first_set(m_ind)));
    endtask

    task automatic cmd(input logic [2:0] op, input int addr, input logic [WIDTH-1:0] data,
                       input logic chain);
        logic [WORDS-1:0] raw;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = IDX_W'(addr);
        cmd_data  = data;
        cmd_chain = chain;
        case (op)
            3'd2: exp_q.push_back(m_mem[addr]);
            3'd6: exp_q.push_back((m_ind != '0) ? m_mem[first_set(m_ind)] : '0);
            default: ;
        endcase
        @(posedge clk);
        case (op)
            3'd1: begin m_mem[addr] = data; m_occ[addr] = 1'b1; end
            3'd3: m_key = data;
            3'd4: m_mask = data;
            3'd5: begin
                for (int w = 0; w < WORDS; w++)
                    raw[w] = m_occ[w] && (((m_mem[w] ^ m_key) & m_mask) == '0);
                m_tmp = m_ind;
                m_ind = chain ? (raw & m_ind) : raw;
            end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = '0;
    endtask

    // monitor: pops expected read data as the design returns it (R1, R9, R10)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10 unexpected rd_valid actual=1 expected=0");
            end else begin
                check("R1/R9 rd_data", 32'(rd_data), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R5 reset state
        check("R5 reset match_vec", 32'(match_vec), 0);
        check("R5 reset prev_vec", 32'(prev_vec), 0);
        check("R10 reset rd_valid", 32'(rd_valid), 0);
        rst_n = 1'b1;

        // R5 no entry stored: a search with key 0 finds nothing
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R5");

        // R1 store and read back
        cmd(3'd1, 0, 16'h1234, 1'b0);
        cmd(3'd1, 1, 16'hAB34, 1'b0);
        cmd(3'd1, 2, 16'h1234, 1'b0);
        cmd(3'd1, 3, 16'h00FF, 1'b0);
        cmd(3'd1, 5, 16'hAB00, 1'b0);
        cmd(3'd2, 1, '0, 1'b0);
        cmd(3'd2, 5, '0, 1'b0);
        check_vectors("R11 after stores");

        // R3 exact search with full mask (reset mask all ones, R2)
        cmd(3'd3, 0, 16'h1234, 1'b0);
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R3");
        check("R3 expected set", 32'(match_vec), 32'h05);
        cmd(3'd6, 0, '0, 1'b0);           // R9 first match is entry 0

        // R4 partial mask; R2 key kept; R6 prev holds old result
        cmd(3'd4, 0, 16'h00FF, 1'b0);
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R4/R6");
        check("R6 prev", 32'(prev_vec), 32'h05);

        // R11 store does not move vectors
        cmd(3'd1, 4, 16'hAB77, 1'b0);     check_vectors("R11");
        cmd(3'd0, 0, '0, 1'b0);           check_vectors("R11 idle");

        // R7 chained search narrows with previous result
        cmd(3'd3, 0, 16'hAB00, 1'b0);
        cmd(3'd4, 0, 16'hFF00, 1'b0);
        cmd(3'd5, 0, '0, 1'b1);           check_vectors("R7");
        check("R7 narrowed", 32'(match_vec), 32'h02);
        check("R8 hit_idx", 32'(hit_idx), 1);
        cmd(3'd6, 0, '0, 1'b0);           // R9 returns entry 1

        // R7 fresh search for contrast: raw set is larger
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R3 fresh");
        check("R3 raw", 32'(match_vec), 32'h32);
        check("R8 hit_idx fresh", 32'(hit_idx), 1);

        // R4 mask all zero: every occupied entry matches
        cmd(3'd4, 0, 16'h0000, 1'b0);
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R4");
        check("R4 all occupied", 32'(match_vec), 32'h3F);

        // R9 no hit: read-first-match gives 0
        cmd(3'd4, 0, 16'hFFFF, 1'b0);
        cmd(3'd3, 0, 16'hFFFF, 1'b0);
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R9 miss");
        check("R8 no hit", 32'(hit), 0);
        cmd(3'd6, 0, '0, 1'b0);

        // R8 hit at highest index
        cmd(3'd1, 7, 16'hFFFF, 1'b0);
        cmd(3'd5, 0, '0, 1'b0);           check_vectors("R8 top");
        cmd(3'd6, 0, '0, 1'b0);

        repeat (3) @(negedge clk);
        check("R10 all reads answered", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule